// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Register Writes

This block drives 32 general-purpose pins organised as two halves of 16. Each half owns a private copy of the configuration registers. The upper half's registers sit 0x80 above the lower half's. A bank's local pin index is the global pin number modulo 16.

Software never needs a read-modify-write to change one pin. Every configuration write carries two masks in one 32-bit word. A 1 in the lower half-word turns the matching pin's attribute on. A 1 in the upper half-word turns it off. A 0 in either half leaves the attribute as it is.

The stored attributes drive the pad controls directly: the output level, the output enable, and the pull-up and pull-down requests. Pad inputs pass through a two-flop synchroniser, and software reads them through a read-back register.

Top module: `gpio_setclr_top`

## Requirements
- R1: After reset every attribute bit is 0. Every register reads 0, and pad_out, pad_oe, pad_pu, pad_pd and pin_level are all 0.
- R2: A write sets a pin's attribute for each 1 in reg_wdata[15:0] (bit n is local pin n). Bits that are 0 in both halves leave the attribute unchanged, and with reg_we low no attribute changes.
- R3: A 1 in reg_wdata[16+n] clears local pin n's attribute. If bits n and 16+n are both 1 in one write, the clear takes effect.
- R4: Addresses 0x00–0x7F reach the bank for pins 0–15, and addresses 0x80–0xFF reach the bank for pins 16–31. A write to one bank never alters the other bank.
- R5: The offsets within a bank are fixed as follows: 0x00 output level, 0x04 drive enable, 0x08 open-drain, 0x0C output inversion, 0x18 pull-up, 0x1C pull-down, 0x20 input select, 0x24 input inversion, and 0x30 read-back.
- R6: Reading a configuration offset returns that attribute's 16 bits in [15:0] and 0 in [31:16].
- R7: Read-back returns the pad input XOR the input-inversion bit. The pad input passes through two flops first, so a change on pad_in is visible after the second rising edge.
- R8: For a pin that is not open-drain, pad_out is the output level XOR the output inversion, and pad_oe is the drive-enable bit.
- R9: For an open-drain pin, pad_out is 0. pad_oe is 1 only when the drive-enable bit is 1 and the inverted level is 0, so a high level releases the pin.
- R10: pin_level gives, per pin, the read-back value when input select is 1 and the stored output level otherwise.
- R11: Writes to the read-back offset, or to an offset not listed in R5, change nothing. Reads of unlisted offsets return 0.
- R12: pad_pu and pad_pd follow the pull-up and pull-down attributes of each pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address (bank select in bit 7) |
| reg_wdata | input | 32 | Write word: set mask [15:0], clear mask [31:16] |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| pad_in | input | 32 | Raw pad input levels |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad drive enables |
| pad_pu | output | 32 | Pull-up requests |
| pad_pd | output | 32 | Pull-down requests |
| pin_level | output | 32 | Per-pin level: read-back or stored output level |

## Verification
The assertions assume that reg_we, reg_addr and reg_wdata are known and settled at each rising edge. They also assume pad_in is free of X, since its two-cycle delay is checked against a past sample of pad_in. pad_in may otherwise change at any time.

The bench changes every input only on the falling clock edge, so every write and every pad change has half a period to settle before it is captured. Every pad_in value it drives is a defined constant.

// File: rtl/gpio_sc_pkg.sv
package gpio_sc_pkg;
  localparam int ATTR_N = 8;

  typedef enum int {
    A_VAL  = 0,
    A_OE   = 1,
    A_OD   = 2,
    A_OINV = 3,
    A_PU   = 4,
    A_PD   = 5,
    A_IE   = 6,
    A_IINV = 7
  } attr_e;

  localparam logic [7:0] RB_OFFSET = 8'h30;

  // Byte offset of each attribute register inside one bank.
  function automatic logic [7:0] attr_offset(input int idx);
    case (idx)
      A_VAL:   return 8'h00;
      A_OE:    return 8'h04;
      A_OD:    return 8'h08;
      A_OINV:  return 8'h0C;
      A_PU:    return 8'h18;
      A_PD:    return 8'h1C;
      A_IE:    return 8'h20;
      default: return 8'h24;
    endcase
  endfunction
endpackage

// File: rtl/gpio_sc_bank.sv
module gpio_sc_bank
  import gpio_sc_pkg::*;
#(
  parameter int HALF  = 16,
  parameter int OFF_W = 7
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [OFF_W-1:0]                 off,
  input  logic [2*HALF-1:0]                wdata,
  output logic [ATTR_N-1:0][HALF-1:0]      attr_q
);
  // Clear wins over set for the same pin.
  function automatic logic [HALF-1:0] setclr(input logic [HALF-1:0] old,
                                              input logic [2*HALF-1:0] w);
    return (old | w[HALF-1:0]) & ~w[2*HALF-1:HALF];
  endfunction

  logic [7:0] off8;
  assign off8 = 8'(off);

  logic [ATTR_N-1:0] hit;
  always_comb begin
    for (int i = 0; i < ATTR_N; i++)
      hit[i] = wr_en && (off8 == attr_offset(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      attr_q <= '0;
    end else begin
      for (int i = 0; i < ATTR_N; i++)
        if (hit[i]) attr_q[i] <= setclr(attr_q[i], wdata);
    end
  end
endmodule

// File: rtl/gpio_sc_sync.sv
module gpio_sc_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_sc_pad.sv
module gpio_sc_pad #(
  parameter int W = 32
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] oinv,
  input  logic [W-1:0] oe,
  input  logic [W-1:0] od,
  output logic [W-1:0] pad_out,
  output logic [W-1:0] pad_oe
);
  function automatic logic [1:0] drive(input logic v, input logic inv,
                                       input logic en, input logic odm);
    logic lvl;
    lvl = v ^ inv;
    if (odm) return {1'b0, en & ~lvl};  // {out, oe}: pull low or release
    return {lvl, en};
  endfunction

  always_comb begin
    for (int i = 0; i < W; i++)
      {pad_out[i], pad_oe[i]} = drive(val[i], oinv[i], oe[i], od[i]);
  end
endmodule

// File: rtl/gpio_setclr_top.sv
module gpio_setclr_top
  import gpio_sc_pkg::*;
#(
  parameter int HALF        = 16,
  parameter int BANKS       = 2,
  parameter int ADDR_W      = 8,
  parameter int BANK_STRIDE = 128
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    reg_we,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [2*HALF-1:0]       reg_wdata,
  output logic [2*HALF-1:0]       reg_rdata,
  input  logic [HALF*BANKS-1:0]   pad_in,
  output logic [HALF*BANKS-1:0]   pad_out,
  output logic [HALF*BANKS-1:0]   pad_oe,
  output logic [HALF*BANKS-1:0]   pad_pu,
  output logic [HALF*BANKS-1:0]   pad_pd,
  output logic [HALF*BANKS-1:0]   pin_level
);
  localparam int NPINS  = HALF * BANKS;
  localparam int OFF_W  = $clog2(BANK_STRIDE);
  localparam int BSEL_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  off;
  logic [BSEL_W-1:0] bank_idx;
  logic [7:0]        off8;
  assign off      = reg_addr[OFF_W-1:0];
  assign bank_idx = reg_addr[ADDR_W-1:OFF_W];
  assign off8     = 8'(off);

  logic [ATTR_N-1:0][HALF-1:0]  bank_attr [BANKS];
  logic [ATTR_N-1:0][NPINS-1:0] attr_all;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    gpio_sc_bank #(.HALF(HALF), .OFF_W(OFF_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (reg_we && (int'(bank_idx) == b)),
      .off    (off),
      .wdata  (reg_wdata),
      .attr_q (bank_attr[b])
    );
    for (genvar a = 0; a < ATTR_N; a++) begin : g_flat
      assign attr_all[a][b*HALF +: HALF] = bank_attr[b][a];
    end
  end

  // Named attribute vectors, one bit per global pin.
  logic [NPINS-1:0] val_q, oe_q, od_q, oinv_q, pu_q, pd_q, ie_q, iinv_q;
  assign val_q  = attr_all[A_VAL];
  assign oe_q   = attr_all[A_OE];
  assign od_q   = attr_all[A_OD];
  assign oinv_q = attr_all[A_OINV];
  assign pu_q   = attr_all[A_PU];
  assign pd_q   = attr_all[A_PD];
  assign ie_q   = attr_all[A_IE];
  assign iinv_q = attr_all[A_IINV];

  logic [NPINS-1:0] sync_q;
  logic [NPINS-1:0] rb_all;

  gpio_sc_sync #(.W(NPINS)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (sync_q)
  );

  assign rb_all = sync_q ^ iinv_q;

  gpio_sc_pad #(.W(NPINS)) u_pad (
    .val     (val_q),
    .oinv    (oinv_q),
    .oe      (oe_q),
    .od      (od_q),
    .pad_out (pad_out),
    .pad_oe  (pad_oe)
  );

  assign pad_pu    = pu_q;
  assign pad_pd    = pd_q;
  assign pin_level = (ie_q & rb_all) | (~ie_q & val_q);

  // Read mux: attribute bits in the low half-word, zero above.
  logic [HALF-1:0] rd_bits;
  always_comb begin
    rd_bits = '0;
    if (int'(bank_idx) < BANKS) begin
      for (int a = 0; a < ATTR_N; a++)
        if (off8 == attr_offset(a)) rd_bits = bank_attr[bank_idx][a];
      if (off8 == RB_OFFSET) rd_bits = rb_all[int'(bank_idx)*HALF +: HALF];
    end
  end
  assign reg_rdata = {{HALF{1'b0}}, rd_bits};
endmodule

// File: rtl/gpio_sc_chk.sv
module gpio_sc_chk #(
  parameter int HALF   = 16,
  parameter int NPINS  = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_addr,
  input logic [2*HALF-1:0] reg_wdata,
  input logic [NPINS-1:0]  pad_in,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  val_q,
  input logic [NPINS-1:0]  oe_q,
  input logic [NPINS-1:0]  od_q,
  input logic [NPINS-1:0]  oinv_q,
  input logic [NPINS-1:0]  pu_q,
  input logic [NPINS-1:0]  pd_q,
  input logic [NPINS-1:0]  ie_q,
  input logic [NPINS-1:0]  iinv_q,
  input logic [NPINS-1:0]  sync_q
);
  logic [1:0] up_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) up_cnt <= '0;
    else if (up_cnt != 2'd3) up_cnt <= up_cnt + 2'd1;
  end

  logic [8*NPINS-1:0] all_attr;
  assign all_attr = {val_q, oe_q, od_q, oinv_q, pu_q, pd_q, ie_q, iinv_q};

  logic [8*HALF-1:0] hi_attr;
  assign hi_attr = {val_q[NPINS-1:HALF], oe_q[NPINS-1:HALF], od_q[NPINS-1:HALF],
                    oinv_q[NPINS-1:HALF], pu_q[NPINS-1:HALF], pd_q[NPINS-1:HALF],
                    ie_q[NPINS-1:HALF], iinv_q[NPINS-1:HALF]};

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_we |=> $stable(all_attr));

  // R3
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == '0 && reg_wdata[0] && reg_wdata[HALF]) |=> !val_q[0]);

  // R4
  bank_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !reg_addr[ADDR_W-1]) |=> $stable(hi_attr));

  // R7
  sync_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (up_cnt >= 2'd2) |-> (sync_q == $past(pad_in, 2)));

  // R8
  pushpull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe & ~od_q) == (oe_q & ~od_q)));

  // R9
  od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((od_q & pad_out) == '0));
endmodule

bind gpio_setclr_top gpio_sc_chk #(.HALF(HALF), .NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .reg_we    (reg_we),
  .reg_addr  (reg_addr),
  .reg_wdata (reg_wdata),
  .pad_in    (pad_in),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .val_q     (val_q),
  .oe_q      (oe_q),
  .od_q      (od_q),
  .oinv_q    (oinv_q),
  .pu_q      (pu_q),
  .pd_q      (pd_q),
  .ie_q      (ie_q),
  .iinv_q    (iinv_q),
  .sync_q    (sync_q)
);

// File: tb/sim_gpio_setclr_top.sv
`timescale 1ns/1ps
module sim_gpio_setclr_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe, pad_pu, pad_pd, pin_level;

  always #2.5 clk = ~clk;

  gpio_setclr_top u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
    .pin_level(pin_level)
  );

  int n_run = 0;
  int n_fail = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  // {address, write word, expected read of the same address}
  localparam int NV = 12;
  localparam logic [71:0] VEC [NV] = '{
    {8'h00, 32'h0000_00F0, 32'h0000_00F0},  // R2 set
    {8'h00, 32'h0000_0003, 32'h0000_00F3},  // R2 zeros keep
    {8'h00, 32'h0010_0000, 32'h0000_00E3},  // R3 clear pin 4
    {8'h00, 32'h0001_0001, 32'h0000_00E2},  // R3 clear wins
    {8'h80, 32'h0000_8001, 32'h0000_8001},  // R4 high bank
    {8'h00, 32'h0000_0000, 32'h0000_00E2},  // R4 low bank untouched
    {8'h04, 32'h0000_FFFF, 32'h0000_FFFF},  // R5 enable offset
    {8'h04, 32'hFF00_0000, 32'h0000_00FF},  // R6 upper zero
    {8'h1C, 32'h0000_1234, 32'h0000_1234},  // R5 pull-down offset
    {8'h30, 32'h0000_FFFF, 32'h0000_0000},  // R11 read-back not writable
    {8'h10, 32'h0000_FFFF, 32'h0000_0000},  // R11 unlisted offset
    {8'h9C, 32'h0000_A5A5, 32'h0000_A5A5}   // R4 high bank pull-down
  };

  logic [31:0] r;

  initial begin
    #(200000 * 5);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h00, r); check("R1 val", r, 32'h0);
    rd(8'h84, r); check("R1 oe high", r, 32'h0);
    check("R1 pad_oe", pad_oe, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], r);
      check($sformatf("vec%0d R2/R3/R4/R5/R6/R11", i), r, VEC[i][31:0]);
    end
    rd(8'h80, r); check("R4 high val intact", r, 32'h0000_8001);

    // R8 push-pull drive
    check("R8 pad_out", pad_out, 32'h8001_00E2);
    wr(8'h0C, 32'h0000_000F);
    check("R8 pad_out inv", pad_out, 32'h8001_00ED);
    check("R8 pad_oe", pad_oe, 32'h0000_00FF);

    // R9 open drain on pins 0..7
    wr(8'h08, 32'h0000_00FF);
    check("R9 pad_out", pad_out, 32'h8001_0000);
    check("R9 pad_oe", pad_oe, 32'h0000_0012);

    // R12 pulls
    wr(8'h98, 32'h0000_0003);
    check("R12 pad_pu", pad_pu, 32'h0003_0000);
    check("R12 pad_pd", pad_pd, 32'hA5A5_1234);

    // R7 synchroniser latency
    @(negedge clk);
    pad_in = 32'hDEAD_BEEF;
    @(negedge clk);
    rd(8'h30, r); check("R7 one edge", r, 32'h0);
    @(negedge clk);
    rd(8'h30, r); check("R7 two edges low", r, 32'h0000_BEEF);
    rd(8'hB0, r); check("R7 two edges high", r, 32'h0000_DEAD);
    wr(8'h24, 32'h0000_00FF);
    rd(8'h30, r); check("R7 invert", r, 32'h0000_BE10);

    // R10 pin level select
    wr(8'h20, 32'h0000_0F00);
    check("R10 pin_level", pin_level, 32'h8001_0EE2);

    // R1 reset again
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    pad_in = '0;
    rd(8'h00, r); check("R1 val after reset", r, 32'h0);
    rd(8'h9C, r); check("R1 pd after reset", r, 32'h0);
    check("R1 pad_out", pad_out, 32'h0);
    check("R1 pad_oe after", pad_oe, 32'h0);
    check("R1 pad_pu", pad_pu, 32'h0);
    check("R1 pad_pd", pad_pd, 32'h0);
    check("R1 pin_level", pin_level, 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule